// File: doc/BRIEF.md
# Hsiao SEC-DED Codec for 16-bit Words

This block protects a 16-bit word with six check bits drawn from an odd-weight-column Hsiao (22,16) code. Its encoder side is purely combinational. It turns a data word into the six check bits that are stored alongside that word.

The decoder side takes a stored word and its stored check bits. It recomputes the check bits from the received data and XORs them with the received ones to form a syndrome. It then classifies that syndrome into one of five verdicts:

- CLEAN: zero syndrome.
- CHECK_BIT: weight-one syndrome.
- DATA_BIT: the syndrome matches a data column.
- DOUBLE: even weight.
- UNKNOWN: odd weight that matches no column.

A single flipped data bit is repaired. Every other verdict leaves the data as it was received. Double errors are found from the parity of the syndrome alone, because every column of the check matrix has odd weight. No extra overall parity bit is needed.

With the parameter `REG_OUT` set, the corrected word and the flags pass through one register stage. They appear with a valid strobe one clock after the input strobe, and the stage holds its contents while no new word arrives. Stored-word layout: positions 0..5 carry check bits c0..c5 and positions 6..21 carry data bits u0..u15.

Top module: `hsiao_secded`

## Requirements
- R1: `enc_check_o[i]` equals ci, where:
  - c0 is the XOR of u0,u1,u2,u3,u5,u6,u10,u11,u12,u13,u14;
  - c1 is the XOR of u3,u4,u5,u6,u7,u10,u11,u12,u13,u15;
  - c2 is the XOR of u0,u4,u6,u7,u8,u10,u11,u12,u14,u15;
  - c3 is the XOR of u0,u1,u5,u7,u8,u9,u10,u11,u13,u14,u15;
  - c4 is the XOR of u1,u2,u8,u9,u10,u12,u13,u14,u15;
  - c5 is the XOR of u2,u3,u4,u9,u11,u12,u13,u14,u15.
  
  Here ui is `enc_data_i[i]`.
- R2: A decoded word whose check bits equal those R1 gives for its data (verdict CLEAN) yields `err_o`=0, `ded_o`=0 and the data unchanged.
- R3: A word with exactly one flipped data bit (verdict DATA_BIT) yields the original data, `err_o`=1, `ded_o`=0.
- R4: A word with exactly one flipped check bit (verdict CHECK_BIT) yields the received data unchanged, `err_o`=1, `ded_o`=0.
- R5: A word with any two of the 22 positions flipped (verdict DOUBLE) yields `err_o`=1, `ded_o`=1, and the received data unchanged.
- R6: An odd-weight syndrome that matches no data column and is not weight one (verdict UNKNOWN, e.g. data 0 with check 6'b010011) yields `err_o`=1, `ded_o`=1, and the received data unchanged.
- R7: `ded_o` is never 1 while `err_o` is 0.
- R8: With `REG_OUT`=1, `dec_valid_o` is 1 exactly in the cycle after a cycle with `dec_valid_i`=1. In that cycle, data and flags reflect the word presented with that strobe.
- R9: With `REG_OUT`=1, while `dec_valid_i` is 0 the registered data and flags keep their values.
- R10: After reset, `dec_valid_o`, `err_o`, `ded_o` and `dec_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_data_i | input | 16 | Word to be encoded |
| enc_check_o | output | 6 | Check bits for `enc_data_i` |
| dec_valid_i | input | 1 | Stored word presented for decoding |
| dec_data_i | input | 16 | Stored data bits |
| dec_check_i | input | 6 | Stored check bits |
| dec_valid_o | output | 1 | Decoded result valid |
| dec_data_o | output | 16 | Corrected or passed-through data |
| err_o | output | 1 | Nonzero syndrome seen |
| ded_o | output | 1 | Uncorrectable word (double error or unmatched odd syndrome) |

## Verification
The hardest verdict to reach from the ports is UNKNOWN. No single or double flip can produce it: it needs three or more flips that happen to cancel onto an unused weight-three pattern. The stimulus reaches it in two ways:
- It applies all ten unused weight-three syndromes directly as check bits over a zero data word.
- It injects random triple flips, which land on this verdict part of the time.

Every single and double flip over the 22 positions is swept exhaustively for several random words. Each sweep is followed by idle cycles with changed inputs to exercise the hold behaviour.

// File: rtl/hsiao_pkg.sv
`timescale 1ns/1ps
package hsiao_pkg;
    localparam int DATA_W = 16;
    localparam int CHK_W  = 6;
    localparam int CW_W   = DATA_W + CHK_W;

    typedef enum logic [2:0] {
        V_CLEAN,
        V_CHECK_BIT,
        V_DATA_BIT,
        V_DOUBLE,
        V_UNKNOWN
    } verdict_e;

    // Column of the parity-check matrix for data bit j (bit i set: ci covers uj)
    function automatic logic [CHK_W-1:0] data_col(input int j);
        case (j)
            0:  data_col = 6'b001101;
            1:  data_col = 6'b011001;
            2:  data_col = 6'b110001;
            3:  data_col = 6'b100011;
            4:  data_col = 6'b100110;
            5:  data_col = 6'b001011;
            6:  data_col = 6'b000111;
            7:  data_col = 6'b001110;
            8:  data_col = 6'b011100;
            9:  data_col = 6'b111000;
            10: data_col = 6'b011111;
            11: data_col = 6'b101111;
            12: data_col = 6'b110111;
            13: data_col = 6'b111011;
            14: data_col = 6'b111101;
            default: data_col = 6'b111110;
        endcase
    endfunction

    // Row mask: which data bits feed check bit i
    function automatic logic [DATA_W-1:0] chk_row(input int i);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int j = 0; j < DATA_W; j++) begin
            m[j] = data_col(j)[i];
        end
        return m;
    endfunction
endpackage

// File: rtl/hsiao_enc.sv
`timescale 1ns/1ps
module hsiao_enc
    import hsiao_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  check_o
);
    for (genvar i = 0; i < CHK_W; i++) begin : g_row
        assign check_o[i] = ^(data_i & chk_row(i));
    end
endmodule

// File: rtl/hsiao_syndrome_dec.sv
`timescale 1ns/1ps
module hsiao_syndrome_dec
    import hsiao_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  check_i,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o,
    output logic              ded_o
);
    logic [CHK_W-1:0]  regen;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] flip;
    verdict_e          verdict;

    hsiao_enc u_regen (
        .data_i  (data_i),
        .check_o (regen)
    );

    assign syn = check_i ^ regen;

    for (genvar j = 0; j < DATA_W; j++) begin : g_match
        assign flip[j] = (syn == data_col(j));
    end

    always_comb begin
        if (syn == '0)                   verdict = V_CLEAN;
        else if (!(^syn))                verdict = V_DOUBLE;
        else if ($countones(syn) == 1)   verdict = V_CHECK_BIT;
        else if (|flip)                  verdict = V_DATA_BIT;
        else                             verdict = V_UNKNOWN;
    end

    always_comb begin
        data_o = data_i;
        err_o  = 1'b1;
        ded_o  = 1'b0;
        unique case (verdict)
            V_CLEAN:     err_o  = 1'b0;
            V_CHECK_BIT: ded_o  = 1'b0;
            V_DATA_BIT:  data_o = data_i ^ flip;
            V_DOUBLE:    ded_o  = 1'b1;
            V_UNKNOWN:   ded_o  = 1'b1;
            default:     ded_o  = 1'b1;
        endcase
    end
endmodule

// File: rtl/hsiao_secded.sv
`timescale 1ns/1ps
module hsiao_secded
    import hsiao_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CHK_W-1:0]  enc_check_o,
    input  logic              dec_valid_i,
    input  logic [DATA_W-1:0] dec_data_i,
    input  logic [CHK_W-1:0]  dec_check_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              err_o,
    output logic              ded_o
);
    logic [DATA_W-1:0] fix_data;
    logic              fix_err;
    logic              fix_ded;

    hsiao_enc u_enc (
        .data_i  (enc_data_i),
        .check_o (enc_check_o)
    );

    hsiao_syndrome_dec u_dec (
        .data_i  (dec_data_i),
        .check_i (dec_check_i),
        .data_o  (fix_data),
        .err_o   (fix_err),
        .ded_o   (fix_ded)
    );

    if (REG_OUT) begin : g_reg
        logic [DATA_W-1:0] data_q;
        logic              err_q, ded_q, vld_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                data_q <= '0;
                err_q  <= 1'b0;
                ded_q  <= 1'b0;
            end else begin
                vld_q <= dec_valid_i;
                if (dec_valid_i) begin
                    data_q <= fix_data;
                    err_q  <= fix_err;
                    ded_q  <= fix_ded;
                end
            end
        end

        assign dec_valid_o = vld_q;
        assign dec_data_o  = data_q;
        assign err_o       = err_q;
        assign ded_o       = ded_q;
    end else begin : g_comb
        assign dec_valid_o = dec_valid_i;
        assign dec_data_o  = fix_data;
        assign err_o       = fix_err;
        assign ded_o       = fix_ded;
    end
endmodule

// File: rtl/hsiao_secded_chk.sv
`timescale 1ns/1ps
module hsiao_secded_chk
    import hsiao_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CHK_W-1:0]  enc_check_o,
    input logic              dec_valid_i,
    input logic [DATA_W-1:0] dec_data_i,
    input logic [CHK_W-1:0]  dec_check_i,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic              err_o,
    input logic              ded_o
);
    if (REG_OUT) begin : g_seq
        assert_ded_implies_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ded_o |-> err_o);

        assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid_i |=> dec_valid_o);

        assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !dec_valid_i |=> !dec_valid_o);

        assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !dec_valid_i |=> ($stable(dec_data_o) && $stable(err_o) && $stable(ded_o)));

        assert_pass_on_ded_R5: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid_i |=> (!ded_o || dec_data_o == $past(dec_data_i)));

        assert_one_bit_fix_R3: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid_i |=> ($countones(dec_data_o ^ $past(dec_data_i)) <= 1));

        assert_clean_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_valid_i && dec_data_i == enc_data_i && dec_check_i == enc_check_o)
            |=> !err_o);
    end else begin : g_cmb
        assert_ded_implies_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ded_o |-> err_o);
    end
endmodule

bind hsiao_secded hsiao_secded_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_data_i  (enc_data_i),
    .enc_check_o (enc_check_o),
    .dec_valid_i (dec_valid_i),
    .dec_data_i  (dec_data_i),
    .dec_check_i (dec_check_i),
    .dec_valid_o (dec_valid_o),
    .dec_data_o  (dec_data_o),
    .err_o       (err_o),
    .ded_o       (ded_o)
);

// File: tb/tb_hsiao_secded.sv
`timescale 1ns/1ps
module tb_hsiao_secded;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] enc_data_i = '0;
    logic [5:0]  enc_check_o;
    logic        dec_valid_i = 1'b0;
    logic [15:0] dec_data_i = '0;
    logic [5:0]  dec_check_i = '0;
    logic        dec_valid_o;
    logic [15:0] dec_data_o;
    logic        err_o, ded_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hsiao_secded #(.REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .enc_data_i(enc_data_i), .enc_check_o(enc_check_o),
        .dec_valid_i(dec_valid_i), .dec_data_i(dec_data_i), .dec_check_i(dec_check_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .err_o(err_o), .ded_o(ded_o)
    );

    function automatic logic [5:0] ref_check(input logic [15:0] u);
        logic [5:0] c;
        c[0] = u[0]^u[1]^u[2]^u[3]^u[5]^u[6]^u[10]^u[11]^u[12]^u[13]^u[14];
        c[1] = u[3]^u[4]^u[5]^u[6]^u[7]^u[10]^u[11]^u[12]^u[13]^u[15];
        c[2] = u[0]^u[4]^u[6]^u[7]^u[8]^u[10]^u[11]^u[12]^u[14]^u[15];
        c[3] = u[0]^u[1]^u[5]^u[7]^u[8]^u[9]^u[10]^u[11]^u[13]^u[14]^u[15];
        c[4] = u[1]^u[2]^u[8]^u[9]^u[10]^u[12]^u[13]^u[14]^u[15];
        c[5] = u[2]^u[3]^u[4]^u[9]^u[11]^u[12]^u[13]^u[14]^u[15];
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one stored word and compare the registered result against the model
    task automatic decode_and_check(input logic [15:0] d, input logic [5:0] c, input string req);
        logic [5:0]  syn;
        logic [15:0] ed;
        bit          ee, eded, hit;
        syn = c ^ ref_check(d);
        ed = d; ee = (syn != 0); eded = 1'b0;
        if (syn != 0 && !(^syn)) eded = 1'b1;
        else if (syn != 0 && $countones(syn) > 1) begin
            hit = 1'b0;
            for (int j = 0; j < 16; j++) begin
                if (ref_check(16'(1) << j) == syn) begin
                    ed[j] = ~ed[j];
                    hit = 1'b1;
                end
            end
            eded = !hit;
        end
        @(negedge clk);
        dec_data_i = d; dec_check_i = c; dec_valid_i = 1'b1;
        @(negedge clk);
        dec_valid_i = 1'b0;
        chk(dec_valid_o === 1'b1, "R8 valid", 32'(dec_valid_o), 32'd1);
        chk(dec_data_o === ed, req, 32'(dec_data_o), 32'(ed));
        chk(err_o === ee, req, 32'(err_o), 32'(ee));
        chk(ded_o === eded, req, 32'(ded_o), 32'(eded));
        chk(!(ded_o && !err_o), "R7 ded without err", {err_o, ded_o}, 32'd0);
    endtask

    task automatic flip_word(input logic [15:0] d, input logic [5:0] c, input int p,
                             output logic [15:0] dq, output logic [5:0] cq);
        dq = d; cq = c;
        if (p < 6) cq[p] = ~cq[p];
        else dq[p-6] = ~dq[p-6];
    endtask

    initial begin
        logic [15:0] d, dq, dr, hold_d;
        logic [5:0]  c, cq, cr;
        logic        hold_e, hold_x;
        logic [5:0]  unused [10];
        void'($urandom(32'h5EC0DED));
        unused = '{6'b010011, 6'b010101, 6'b010110, 6'b011010, 6'b100101,
                   6'b101001, 6'b101010, 6'b101100, 6'b110010, 6'b110100};

        #12;
        // R10: reset state
        chk(dec_valid_o === 1'b0, "R10 valid", 32'(dec_valid_o), 0);
        chk(err_o === 1'b0, "R10 err", 32'(err_o), 0);
        chk(ded_o === 1'b0, "R10 ded", 32'(ded_o), 0);
        chk(dec_data_o === 16'h0, "R10 data", 32'(dec_data_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1: encoder, directed one-hot and random words
        for (int j = 0; j < 16; j++) begin
            @(negedge clk); enc_data_i = 16'(1) << j; #1;
            chk(enc_check_o === ref_check(enc_data_i), "R1 onehot", 32'(enc_check_o), 32'(ref_check(enc_data_i)));
        end
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); enc_data_i = 16'($urandom); #1;
            chk(enc_check_o === ref_check(enc_data_i), "R1 random", 32'(enc_check_o), 32'(ref_check(enc_data_i)));
        end

        // R2: clean words including corners
        decode_and_check(16'h0000, ref_check(16'h0000), "R2 zero");
        decode_and_check(16'hFFFF, ref_check(16'hFFFF), "R2 ones");
        for (int k = 0; k < 20; k++) begin
            d = 16'($urandom);
            decode_and_check(d, ref_check(d), "R2 clean");
        end

        // R3 R4 R5: exhaustive single and double flips over several words
        for (int w = 0; w < 4; w++) begin
            d = (w == 0) ? 16'hA5C3 : 16'($urandom);
            c = ref_check(d);
            for (int p = 0; p < 22; p++) begin
                flip_word(d, c, p, dq, cq);
                decode_and_check(dq, cq, (p < 6) ? "R4 check flip" : "R3 data flip");
            end
            for (int p = 0; p < 22; p++) begin
                for (int q = p + 1; q < 22; q++) begin
                    flip_word(d, c, p, dq, cq);
                    flip_word(dq, cq, q, dr, cr);
                    decode_and_check(dr, cr, "R5 double flip");
                end
            end
            // R9: idle with changed inputs, outputs hold
            hold_d = dec_data_o; hold_e = err_o; hold_x = ded_o;
            @(negedge clk); dec_data_i = ~dec_data_i; dec_check_i = ~dec_check_i;
            @(negedge clk); @(negedge clk);
            chk(dec_data_o === hold_d, "R9 hold data", 32'(dec_data_o), 32'(hold_d));
            chk(err_o === hold_e && ded_o === hold_x, "R9 hold flags", {err_o, ded_o}, {hold_e, hold_x});
            chk(dec_valid_o === 1'b0, "R8 idle valid", 32'(dec_valid_o), 0);
        end

        // R6: unmatched odd syndromes, directed and via random triple flips
        for (int k = 0; k < 10; k++) decode_and_check(16'h0000, unused[k], "R6 unmatched");
        for (int k = 0; k < 200; k++) begin
            int p1, p2, p3;
            d = 16'($urandom); c = ref_check(d);
            p1 = $urandom_range(0, 21);
            p2 = (p1 + 1 + $urandom_range(0, 19)) % 22;
            p3 = p1;
            while (p3 == p1 || p3 == p2) p3 = $urandom_range(0, 21);
            flip_word(d, c, p1, dq, cq);
            flip_word(dq, cq, p2, dr, cr);
            flip_word(dr, cr, p3, dq, cq);
            decode_and_check(dq, cq, "R6 triple flip");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule